// File: doc/BRIEF.md
# Self-Acknowledging Prioritized Interrupt Controller

This block gathers level-sensitive hardware interrupt lines and per-CPU inter-processor interrupts (IPIs). It raises one interrupt request per CPU. Every line has a mask bit, a software-trigger bit and a CPU routing set. The pending state the controller sees is the input level ORed with the software bit. Each CPU also owns two IPI sources, numbered 0 ("self") and 1 ("other"). The hardware treats the two alike, and any CPU may raise either one on any CPU.

Each CPU services its interrupts through a single event register. A read of that register returns the most urgent source that is pending, unmasked and routed to that CPU. The same read also acknowledges the source. A returned hardware line gets its mask bit set, and a returned IPI gets its pending bit cleared. Software then re-enables the line once the device has been serviced. All other control registers are write-one-to-set and write-one-to-clear, so no read-modify-write sequence is ever needed.

Register addresses are word indices. Bits [ADDR_W-1:8] select a window, where window 0 targets the CPU that issues the access (`req_cpu`) and window k (1..NUM_CPUS) targets CPU k-1. Bits [7:0] select the register. The offsets are: 0x00 event (read-and-acknowledge); 0x01 IPI raise (write) or IPI pending (read); 0x02 IPI clear; 0x03 IPI mask set (write) or IPI mask (read); 0x04 IPI mask clear; 0x08 line mask set (write) or mask (read); 0x09 line mask clear; 0x0A software-trigger set (write) or software bits (read); 0x0B software-trigger clear; 0x20+n routing set of line n, one bit per CPU. Reads answer one cycle after the request on `rsp_valid`/`rsp_rdata`.

Top module: `aic_top`

## Requirements
- R1: A hardware line is pending exactly while its input is high; no edge is latched.
- R2: A line whose mask bit is 1 never contributes to any `irq_out` bit or any event read; after reset every line is masked.
- R3: A line reaches CPU c only if bit c of its routing register (offset 0x20+n) is 1; after reset every line routes to CPU 0 only.
- R4: A line's effective pending state is its input level ORed with its software-trigger bit.
- R5: Writing bits [1:0] to offset 0x01 in the window of CPU t raises IPI 0 and/or IPI 1 of CPU t, from whichever CPU performs the write.
- R6: The event word is {type[31:16], number[15:0]} with type 0 = none, 1 = hardware line, 2 = IPI. It names unmasked IPI 0, otherwise unmasked IPI 1, otherwise the lowest-numbered pending, unmasked, routed line.
- R7: An event read that returns a hardware line sets that line's mask bit at the same clock edge.
- R8: An event read that returns an IPI clears that IPI's pending bit, so the IPI is not delivered again until it is raised again.
- R9: Window 0 reaches the registers of the CPU on `req_cpu`, and window k reaches CPU k-1 whatever `req_cpu` is.
- R10: An event read with nothing deliverable returns 0 and changes no mask, software or IPI state.
- R11: Mask, software-trigger and IPI set/clear registers act only on bits written as 1; zero bits leave state unchanged.
- R12: `irq_out[c]` is a registered OR of every deliverable source of CPU c. It follows a change of input or state one clock edge later.
- R13: After reset `irq_out` is 0, all software and IPI bits are 0 and all IPI masks are 0 (enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQS | Level-sensitive hardware interrupt lines |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | CPU issuing the access (used by window 0) |
| req_addr | input | ADDR_W | Window and register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NUM_CPUS | Interrupt request, one per CPU |

## Verification
The bench checks that an IPI outranks a lower-numbered hardware line. A design that ran a plain priority search over all sources would return the line first. It checks that an acknowledged line stays quiet while its input is still high. A design without the automatic mask would deliver that line again at once. Empty event reads are repeated to catch a design that masks line 0 or clears an IPI on a "none" result. Explicit-window reads are issued from the other CPU to catch a design that decodes the target from `req_cpu` alone. Random traffic then mixes line levels, routing changes, software triggers and IPIs against a reference model, and compares every event word and every `irq_out` value.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [15:0] {
    SRC_NONE = 16'd0,
    SRC_HW   = 16'd1,
    SRC_IPI  = 16'd2
  } src_t;

  localparam logic [7:0] OFF_EVENT     = 8'h00;
  localparam logic [7:0] OFF_IPI_RAISE = 8'h01;
  localparam logic [7:0] OFF_IPI_CLR   = 8'h02;
  localparam logic [7:0] OFF_IPI_MSET  = 8'h03;
  localparam logic [7:0] OFF_IPI_MCLR  = 8'h04;
  localparam logic [7:0] OFF_MASK_SET  = 8'h08;
  localparam logic [7:0] OFF_MASK_CLR  = 8'h09;
  localparam logic [7:0] OFF_SW_SET    = 8'h0A;
  localparam logic [7:0] OFF_SW_CLR    = 8'h0B;
  localparam logic [7:0] OFF_ROUTE     = 8'h20;
endpackage

// File: rtl/aic_line_bank.sv
module aic_line_bank #(
  parameter int NUM_IRQS = 16,
  parameter int NUM_CPUS = 2,
  localparam int IDX_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_IRQS-1:0]                mask_set,
  input  logic [NUM_IRQS-1:0]                mask_clr,
  input  logic [NUM_IRQS-1:0]                sw_set,
  input  logic [NUM_IRQS-1:0]                sw_clr,
  input  logic                               route_we,
  input  logic [IDX_W-1:0]                   route_idx,
  input  logic [NUM_CPUS-1:0]                route_wdata,
  output logic [NUM_IRQS-1:0]                mask_q,
  output logic [NUM_IRQS-1:0]                sw_q,
  output logic [NUM_IRQS-1:0][NUM_CPUS-1:0]  route_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sw_q   <= '0;
      for (int i = 0; i < NUM_IRQS; i++) route_q[i] <= NUM_CPUS'(1);
    end else begin
      mask_q <= (mask_q & ~mask_clr) | mask_set;
      sw_q   <= (sw_q & ~sw_clr) | sw_set;
      if (route_we) route_q[route_idx] <= route_wdata;
    end
  end
endmodule

// File: rtl/aic_ipi_bank.sv
module aic_ipi_bank #(
  parameter int NUM_CPUS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CPUS-1:0][1:0] raise,
  input  logic [NUM_CPUS-1:0][1:0] clear,
  input  logic [NUM_CPUS-1:0][1:0] mset,
  input  logic [NUM_CPUS-1:0][1:0] mclr,
  output logic [NUM_CPUS-1:0][1:0] pend_q,
  output logic [NUM_CPUS-1:0][1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clear) | raise;
      mask_q <= (mask_q & ~mclr) | mset;
    end
  end
endmodule

// File: rtl/aic_prio_pick.sv
module aic_prio_pick
  import aic_pkg::*;
#(
  parameter int NUM_IRQS = 16
) (
  input  logic [NUM_IRQS-1:0] hw_req,
  input  logic [1:0]          ipi_req,
  output logic [DATA_W-1:0]   evt,
  output logic                any
);
  always_comb begin
    evt = '0;
    for (int i = NUM_IRQS - 1; i >= 0; i--) begin
      if (hw_req[i]) evt = {SRC_HW, 16'(i)};
    end
    if (ipi_req[1]) evt = {SRC_IPI, 16'd1};
    if (ipi_req[0]) evt = {SRC_IPI, 16'd0};
    any = (|hw_req) | (|ipi_req);
  end
endmodule

// File: rtl/aic_top.sv
module aic_top
  import aic_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 16,
  parameter int ADDR_W   = 12,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_IRQS-1:0] irq_in,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CPU_W-1:0]    req_cpu,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [NUM_CPUS-1:0] irq_out
);
  localparam int IDX_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1;
  localparam int WIN_W = ADDR_W - 8;

  logic [WIN_W-1:0] win;
  logic [7:0]       off;
  logic [CPU_W-1:0] tgt;
  logic             tgt_ok, wr_en, rd_en, ev_rd;
  logic             route_hit;
  logic [7:0]       route_off;

  assign win = req_addr[ADDR_W-1:8];
  assign off = req_addr[7:0];

  always_comb begin
    tgt    = (win == '0) ? req_cpu : CPU_W'(win - 1'b1);
    tgt_ok = (int'(win) <= NUM_CPUS) && (int'(tgt) < NUM_CPUS);
  end
  assign wr_en     = req_valid & req_write & tgt_ok;
  assign rd_en     = req_valid & ~req_write & tgt_ok;
  assign ev_rd     = rd_en && (off == OFF_EVENT);
  assign route_off = off - OFF_ROUTE;
  assign route_hit = (off >= OFF_ROUTE) && (int'(route_off) < NUM_IRQS);

  // state banks
  logic [NUM_IRQS-1:0]               mask_q, sw_q, mask_set, mask_clr, sw_set, sw_clr;
  logic [NUM_IRQS-1:0][NUM_CPUS-1:0] route_q;
  logic [NUM_CPUS-1:0][1:0]          ipi_pend, ipi_mask, ipi_raise, ipi_clr, ipi_mset, ipi_mclr;
  logic [NUM_IRQS-1:0]               ack_hw;

  aic_line_bank #(.NUM_IRQS(NUM_IRQS), .NUM_CPUS(NUM_CPUS)) u_lines (
    .clk(clk), .rst(rst),
    .mask_set(mask_set), .mask_clr(mask_clr),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .route_we(wr_en && route_hit), .route_idx(route_off[IDX_W-1:0]),
    .route_wdata(req_wdata[NUM_CPUS-1:0]),
    .mask_q(mask_q), .sw_q(sw_q), .route_q(route_q)
  );

  aic_ipi_bank #(.NUM_CPUS(NUM_CPUS)) u_ipi (
    .clk(clk), .rst(rst),
    .raise(ipi_raise), .clear(ipi_clr), .mset(ipi_mset), .mclr(ipi_mclr),
    .pend_q(ipi_pend), .mask_q(ipi_mask)
  );

  // per-CPU deliverable sets and priority pick
  logic [NUM_IRQS-1:0]                 eff_pend;
  logic [NUM_CPUS-1:0][NUM_IRQS-1:0]   hw_req;
  logic [NUM_CPUS-1:0][DATA_W-1:0]     evt;
  logic [NUM_CPUS-1:0]                 any;

  assign eff_pend = irq_in | sw_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_line
      assign hw_req[c][i] = eff_pend[i] & ~mask_q[i] & route_q[i][c];
    end
    aic_prio_pick #(.NUM_IRQS(NUM_IRQS)) u_pick (
      .hw_req(hw_req[c]), .ipi_req(ipi_pend[c] & ~ipi_mask[c]),
      .evt(evt[c]), .any(any[c])
    );
  end

  // write decode and acknowledge side effects
  logic [DATA_W-1:0] sel_evt;
  assign sel_evt = evt[tgt];

  always_comb begin
    ack_hw    = '0;
    ipi_raise = '0;
    ipi_clr   = '0;
    ipi_mset  = '0;
    ipi_mclr  = '0;
    if (ev_rd && sel_evt[31:16] == SRC_HW) ack_hw[sel_evt[IDX_W-1:0]] = 1'b1;
    if (ev_rd && sel_evt[31:16] == SRC_IPI) ipi_clr[tgt][sel_evt[0]] = 1'b1;
    if (wr_en) begin
      case (off)
        OFF_IPI_RAISE: ipi_raise[tgt] = req_wdata[1:0];
        OFF_IPI_CLR:   ipi_clr[tgt]   = req_wdata[1:0];
        OFF_IPI_MSET:  ipi_mset[tgt]  = req_wdata[1:0];
        OFF_IPI_MCLR:  ipi_mclr[tgt]  = req_wdata[1:0];
        default: ;
      endcase
    end
    mask_set = ack_hw | ((wr_en && off == OFF_MASK_SET) ? req_wdata[NUM_IRQS-1:0] : '0);
    mask_clr = (wr_en && off == OFF_MASK_CLR) ? req_wdata[NUM_IRQS-1:0] : '0;
    sw_set   = (wr_en && off == OFF_SW_SET)   ? req_wdata[NUM_IRQS-1:0] : '0;
    sw_clr   = (wr_en && off == OFF_SW_CLR)   ? req_wdata[NUM_IRQS-1:0] : '0;
  end

  // registered read path and request outputs
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_EVENT:     rd_mux = sel_evt;
      OFF_IPI_RAISE: rd_mux = DATA_W'(ipi_pend[tgt]);
      OFF_IPI_MSET:  rd_mux = DATA_W'(ipi_mask[tgt]);
      OFF_MASK_SET:  rd_mux = DATA_W'(mask_q);
      OFF_SW_SET:    rd_mux = DATA_W'(sw_q);
      default:       if (route_hit) rd_mux = DATA_W'(route_q[route_off[IDX_W-1:0]]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq_out   <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= rd_en ? rd_mux : '0;
      irq_out   <= any;
    end
  end
endmodule

// File: rtl/aic_checks.sv
module aic_checks #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 16,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [31:0]         req_wdata,
  input logic                rsp_valid,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_CPUS-1:0] irq_out,
  input logic [NUM_IRQS-1:0] mask_q
);
  localparam int IDX_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1;

  logic ev_rd, mset_wr, mclr_wr;
  assign ev_rd   = req_valid && !req_write && req_addr[7:0] == 8'h00;
  assign mset_wr = req_valid && req_write && req_addr[7:0] == 8'h08 && int'(req_addr[ADDR_W-1:8]) == 1;
  assign mclr_wr = req_valid && req_write && req_addr[7:0] == 8'h09 && int'(req_addr[ADDR_W-1:8]) == 1;

  // R7: a returned hardware line is already masked when its number appears
  p_ack_masks_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_rdata[31:16] == 16'd1) |-> mask_q[rsp_rdata[IDX_W-1:0]]);

  // R10: an empty event read leaves the masks alone
  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ev_rd |=> (rsp_rdata != 32'd0 || $stable(mask_q)));

  // R11: mask set writes land on exactly the 1 bits
  p_mask_set_r11: assert property (@(posedge clk) disable iff (rst)
    mset_wr |=> ((mask_q & $past(req_wdata[NUM_IRQS-1:0])) == $past(req_wdata[NUM_IRQS-1:0])));

  p_mask_clr_r11: assert property (@(posedge clk) disable iff (rst)
    mclr_wr |=> ((mask_q & $past(req_wdata[NUM_IRQS-1:0])) == '0));

  // R13: leaving reset, all lines masked and no request raised
  p_reset_state_r13: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '1 && irq_out == '0));
endmodule

bind aic_top aic_checks #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq_out(irq_out), .mask_q(mask_q)
);

// File: tb/aic_top_test.sv
`timescale 1ns/1ps
module aic_top_test;
  localparam int C = 2;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]    req_cpu = '0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [C-1:0]  irq_out;

  aic_top #(.NUM_CPUS(C), .NUM_IRQS(N), .ADDR_W(12)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [N-1:0] m_mask = '1, m_sw = '0;
  logic [C-1:0] m_route [N];
  logic [1:0]   m_ipi [C];
  logic [1:0]   m_ipim [C];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_evt(int c);
    if (m_ipi[c][0] && !m_ipim[c][0]) return {16'd2, 16'd0};
    if (m_ipi[c][1] && !m_ipim[c][1]) return {16'd2, 16'd1};
    for (int i = 0; i < N; i++)
      if ((irq_in[i] | m_sw[i]) && !m_mask[i] && m_route[i][c]) return {16'd1, 16'(i)};
    return 32'd0;
  endfunction

  function automatic logic [C-1:0] exp_irq();
    logic [C-1:0] v;
    for (int c = 0; c < C; c++) v[c] = (exp_evt(c) != 0);
    return v;
  endfunction

  task automatic bus(bit w, int win, int caller, int off, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_cpu = 1'(caller);
    req_addr = {4'(win), 8'(off)}; req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(int win, int caller, int off, logic [31:0] d);
    int t = (win == 0) ? caller : win - 1;
    logic [31:0] dummy;
    bus(1'b1, win, caller, off, d, dummy);
    case (off)
      1: m_ipi[t]  = m_ipi[t] | d[1:0];
      2: m_ipi[t]  = m_ipi[t] & ~d[1:0];
      3: m_ipim[t] = m_ipim[t] | d[1:0];
      4: m_ipim[t] = m_ipim[t] & ~d[1:0];
      8: m_mask = m_mask | d[N-1:0];
      9: m_mask = m_mask & ~d[N-1:0];
      10: m_sw = m_sw | d[N-1:0];
      11: m_sw = m_sw & ~d[N-1:0];
      default: if (off >= 32 && off < 32 + N) m_route[off-32] = d[C-1:0];
    endcase
  endtask

  task automatic rd(int win, int caller, int off, output logic [31:0] v);
    bus(1'b0, win, caller, off, 32'd0, v);
  endtask

  task automatic ev_read(string req, int win, int caller, output logic [31:0] got);
    int t = (win == 0) ? caller : win - 1;
    logic [31:0] e;
    e = exp_evt(t);
    rd(win, caller, 0, got);
    chk(req, got, e);
    if (e[31:16] == 16'd1) m_mask[e[3:0]] = 1'b1;
    if (e[31:16] == 16'd2) m_ipi[t][e[0]] = 1'b0;
  endtask

  task automatic set_irq(logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic chk_irq(string req);
    @(negedge clk);
    chk(req, 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) m_route[i] = 2'b01;
    for (int c = 0; c < C; c++) begin m_ipi[c] = 0; m_ipim[c] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13 reset state
    chk("R13 irq_out", 32'(irq_out), 32'd0);
    rd(1, 0, 8, v);  chk("R13 mask all set", v, 32'h0000_ffff);
    rd(1, 0, 10, v); chk("R13 sw clear", v, 32'd0);
    rd(2, 0, 1, v);  chk("R13 ipi pend clear", v, 32'd0);
    ev_read("R10 empty read", 0, 0, v); chk("R10 empty value", v, 32'd0);

    // R1 / R12 level pending, routed to cpu0 only
    wr(0, 0, 9, 32'h20);
    set_irq(16'h0020);
    chk_irq("R1 R12 irq follows level");
    chk("R3 cpu1 not routed", 32'(irq_out[1]), 32'd0);

    // R6 / R7 acknowledge masks the line
    ev_read("R6 line 5", 0, 0, v); chk("R6 line 5 value", v, 32'h0001_0005);
    rd(1, 0, 8, v); chk("R7 mask set by ack", v, 32'h0000_ffff);
    chk_irq("R7 irq drops after ack");
    chk("R7 irq low literal", 32'(irq_out), 32'd0);

    // R10 empty read changes nothing
    ev_read("R10 second empty", 0, 0, v); chk("R10 zero word", v, 32'd0);
    rd(1, 0, 8, v); chk("R10 mask unchanged", v, 32'h0000_ffff);

    // R2 masking
    wr(1, 1, 9, 32'h20); chk_irq("R2 unmask delivers");
    wr(1, 1, 8, 32'h20); chk_irq("R2 mask blocks");
    chk("R2 irq low literal", 32'(irq_out), 32'd0);

    // R4 software trigger
    wr(0, 0, 10, 32'h200); wr(0, 0, 9, 32'h200);
    chk_irq("R4 sw trigger delivers");
    rd(1, 0, 10, v); chk("R4 sw readback", v, 32'h200);

    // R6 lowest number first
    set_irq(16'h0028); wr(0, 0, 9, 32'h8);
    ev_read("R6 lowest first", 0, 0, v); chk("R6 got 3", v, 32'h0001_0003);
    ev_read("R6 next 9", 0, 0, v);       chk("R6 got 9", v, 32'h0001_0009);

    // R3 / R9 routing and explicit window
    wr(0, 0, 32 + 7, 32'h2); wr(0, 0, 9, 32'h80);
    set_irq(16'h00a8);
    chk_irq("R3 line 7 to cpu1");
    chk("R3 irq vector", 32'(irq_out), 32'h2);
    ev_read("R9 explicit window cpu1", 2, 0, v); chk("R9 got 7", v, 32'h0001_0007);
    ev_read("R9 alias from cpu1 empty", 0, 1, v); chk("R9 alias empty", v, 32'd0);

    // R5 / R8 IPI raised by another CPU, priority over lines
    wr(0, 0, 10, 32'h4); wr(0, 0, 9, 32'h4);
    wr(1, 1, 1, 32'h2);
    chk_irq("R5 ipi raises irq");
    ev_read("R6 ipi before line", 0, 0, v); chk("R6 ipi word", v, 32'h0002_0001);
    rd(1, 1, 1, v); chk("R8 ipi cleared", v, 32'd0);
    ev_read("R8 then line 2", 0, 0, v); chk("R8 line 2 word", v, 32'h0001_0002);

    // R11 zero writes have no effect
    rd(1, 0, 8, v); wr(1, 0, 8, 32'd0); wr(1, 0, 9, 32'd0);
    rd(1, 0, 8, v); chk("R11 mask unchanged", v, 32'(m_mask));
    wr(1, 0, 11, 32'd0);
    rd(1, 0, 10, v); chk("R11 sw unchanged", v, 32'(m_sw));

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      int op, w, cl;
      op = int'($urandom % 10);
      w  = int'($urandom % (C + 1));
      cl = int'($urandom % C);
      case (op)
        0: set_irq(N'($urandom));
        1, 2: wr(w, cl, 9, $urandom & $urandom);
        3: wr(w, cl, 8, $urandom);
        4: wr(w, cl, ($urandom % 2 == 0) ? 10 : 11, $urandom & $urandom & $urandom);
        5: wr(w, cl, 32 + int'($urandom % N), $urandom % 4);
        6: wr(w, cl, 1 + int'($urandom % 2), $urandom % 4);
        7: wr(w, cl, 3 + int'($urandom % 2), $urandom % 4);
        default: ev_read("R6 R7 R8 random event", w, cl, v);
      endcase
      chk_irq("R12 random irq_out");
      if (k % 50 == 0) begin
        rd(1, 0, 8, v); chk("R11 random mask", v, 32'(m_mask));
      end
    end

    finish_run();
  end
endmodule